// File: doc/BRIEF.md
# Composite Clock Select-Divide-Gate Cell

This cell derives one output clock from a primary source and up to eight secondary sources. It has four stages. The first is a two-level source choice: a bypass switch picks either the primary source or one of several secondary sources, and a 3-bit field names the secondary source. The second is a programmable divider whose ratio comes from a lookup table. The third is a fixed divide-by-3 path that overrides the programmable divider whenever it is switched on. The last is an output gate. All control fields are static configuration inputs.

The cell runs in a single fast clock domain. Each source appears as a one-cycle tick pulse, and one tick marks one edge of that source, so a full source period is two ticks. A divide ratio R gives an output period of 2R ticks of the chosen source. A phase state machine, whose states are `ST_IDLE`, `ST_HIGH` and `ST_LOW`, generates the divided clock. `ST_IDLE` is the reset state and holds the output low. On the first tick, `ST_IDLE` moves to `ST_HIGH`. When the high count runs out on a tick, `ST_HIGH` moves to `ST_LOW`. When the low count runs out on a tick, `ST_LOW` moves back to `ST_HIGH`. The divider setting and the enable are captured only on the two transitions into `ST_HIGH`, which are the period boundaries. The cell also reports the combined parent index: 0 means the primary source, and k means secondary source k-1.

Top module: `clk_compose_cell`

## Requirements
- R1: While `rst_ni` is low, `clk_o` is 0. After reset is released, the first source tick starts a high phase, so `clk_o` is 1 one cycle later.
- R2: With `src_alt_i`=0, the primary tick stream drives the divider and `parent_idx_o` is 0.
- R3: With `src_alt_i`=1, secondary tick stream `sec_tick_i[src_sel_i]` drives the divider and `parent_idx_o` equals `src_sel_i`+1.
- R4: With `div_on_i`=1 and `div3_on_i`=0, `div_code_i` values 0 through 7 select ratios 1, 2, 4, 6, 8, 12, 1 and 1. The output period is 2×ratio source ticks.
- R5: With `div_on_i`=0 and `div3_on_i`=0, the ratio is 1 whatever `div_code_i` holds.
- R6: With `div3_on_i`=1, the ratio is 3 whatever `div_on_i` and `div_code_i` hold.
- R7: For ratios 1 and even ratios, the high phase is one half of the period. For ratio 3, the output is high for 2 ticks and low for 4 ticks.
- R8: A change to the divider controls takes effect only at the next period boundary: the running period keeps its old length. The output changes only on a source tick.
- R9: The enable is sampled only at a period boundary. Dropping `en_i` during a high phase does not shorten that phase, and raising it again resumes the output at the next boundary.
- R10: If the enable was 0 at a period boundary, `clk_o` stays 0 for that whole period.
- R11: With `HAS_MUX`=0, the primary source is always used and `parent_idx_o` is 0. With `HAS_GATE`=0, the output runs whatever `en_i` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast sampling clock of the cell |
| rst_ni | input | 1 | Asynchronous active-low reset |
| prim_tick_i | input | 1 | Edge tick of the primary source |
| sec_tick_i | input | NUM_SEC | Edge ticks of the secondary sources |
| src_alt_i | input | 1 | 0: primary source, 1: secondary source |
| src_sel_i | input | 3 | Secondary source number |
| div_on_i | input | 1 | 0: programmable divider bypassed (ratio 1) |
| div_code_i | input | 3 | Ratio table code |
| div3_on_i | input | 1 | Fixed divide-by-3, dominant |
| en_i | input | 1 | Output gate enable |
| clk_o | output | 1 | Divided, gated output clock |
| parent_idx_o | output | IDX_W | Combined parent index (0 = primary) |

## Verification
The bench builds two instances. The first uses the defaults (eight secondary sources, selector and gate present). Against it, every ratio code and both bypass paths are measured, along with the divide-by-3 override, several secondary sources ticking at different rates, mid-period setting changes and enable drops. The second instance is built with `HAS_MUX`=0 and `HAS_GATE`=0. It runs with the alternate source chosen and the enable low, which shows that both stripped variants fall back to the primary source and to an always-on output.

// File: rtl/ccc_pkg.sv
package ccc_pkg;

    localparam int SEL_W  = 3;
    localparam int CODE_W = 3;
    localparam int LEN_W  = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } phase_e;

    typedef struct packed {
        logic [LEN_W-1:0] hi;
        logic [LEN_W-1:0] lo;
    } phase_len_t;

    // Ratio lookup; codes past the last real ratio fall back to 1.
    function automatic logic [LEN_W-1:0] code_ratio(input logic [CODE_W-1:0] code);
        logic [LEN_W-1:0] r;
        unique case (code)
            3'd0:    r = 4'd1;
            3'd1:    r = 4'd2;
            3'd2:    r = 4'd4;
            3'd3:    r = 4'd6;
            3'd4:    r = 4'd8;
            3'd5:    r = 4'd12;
            default: r = 4'd1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ccc_src_select.sv
module ccc_src_select
    import ccc_pkg::*;
#(
    parameter int NUM_SEC = 8,
    parameter bit HAS_MUX = 1'b1,
    parameter int IDX_W   = 4
) (
    input  logic               prim_tick_i,
    input  logic [NUM_SEC-1:0] sec_tick_i,
    input  logic               alt_i,
    input  logic [SEL_W-1:0]   sel_i,
    output logic               tick_o,
    output logic [IDX_W-1:0]   idx_o
);

    generate
        if (HAS_MUX) begin : g_mux
            logic sec_hit;
            always_comb begin
                sec_hit = 1'b0;
                for (int i = 0; i < NUM_SEC; i++) begin
                    if (sel_i == SEL_W'(i)) begin
                        sec_hit = sec_tick_i[i];
                    end
                end
            end
            assign tick_o = alt_i ? sec_hit : prim_tick_i;
            assign idx_o  = alt_i ? (IDX_W'(sel_i) + IDX_W'(1)) : '0;
        end else begin : g_single
            logic unused_sel;
            assign unused_sel = ^{sec_tick_i, alt_i, sel_i};
            assign tick_o     = prim_tick_i;
            assign idx_o      = '0;
        end
    endgenerate

endmodule

// File: rtl/ccc_ratio_decode.sv
module ccc_ratio_decode
    import ccc_pkg::*;
(
    input  logic              div_on_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              div3_i,
    output logic [LEN_W-1:0]  ratio_o,
    output phase_len_t        len_o
);

    always_comb begin
        if (div3_i) begin
            ratio_o = LEN_W'(3);
        end else if (!div_on_i) begin
            ratio_o = LEN_W'(1);
        end else begin
            ratio_o = code_ratio(code_i);
        end
        // Divide-by-3 keeps one source period high and two low.
        if (ratio_o == LEN_W'(3)) begin
            len_o.hi = LEN_W'(2);
            len_o.lo = LEN_W'(4);
        end else begin
            len_o.hi = ratio_o;
            len_o.lo = ratio_o;
        end
    end

endmodule

// File: rtl/ccc_phase_fsm.sv
module ccc_phase_fsm
    import ccc_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       tick_i,
    input  logic       en_i,
    input  phase_len_t len_i,
    output logic       clk_o
);

    phase_e           state_q, state_d;
    logic [LEN_W-1:0] cnt_q, cnt_d;
    phase_len_t       len_q, len_d;
    logic             gate_q, gate_d;
    logic             clk_q;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        len_d   = len_q;
        gate_d  = gate_q;
        unique case (state_q)
            ST_IDLE: begin
                if (tick_i) begin
                    state_d = ST_HIGH;
                    len_d   = len_i;
                    gate_d  = en_i;
                    cnt_d   = len_i.hi - LEN_W'(1);
                end
            end
            ST_HIGH: begin
                if (tick_i) begin
                    if (cnt_q == '0) begin
                        state_d = ST_LOW;
                        cnt_d   = len_q.lo - LEN_W'(1);
                    end else begin
                        cnt_d = cnt_q - LEN_W'(1);
                    end
                end
            end
            ST_LOW: begin
                if (tick_i) begin
                    if (cnt_q == '0) begin
                        state_d = ST_HIGH;
                        len_d   = len_i;
                        gate_d  = en_i;
                        cnt_d   = len_i.hi - LEN_W'(1);
                    end else begin
                        cnt_d = cnt_q - LEN_W'(1);
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            len_q   <= '0;
            gate_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            len_q   <= len_d;
            gate_q  <= gate_d;
        end
    end

    // Output register: glitch-free divided and gated clock
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            clk_q <= 1'b0;
        end else begin
            clk_q <= (state_d == ST_HIGH) && gate_d;
        end
    end

    assign clk_o = clk_q;

    // R1: no output pulse before the first tick
    a_r1_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_IDLE) |-> !clk_q);

    // R8: output moves only on a source tick
    a_r8_change_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i |=> $stable(clk_q));

    // R8: latched phase lengths change only on entering a high phase
    a_r8_len_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (len_q != $past(len_q)) |-> (state_q == ST_HIGH && $past(state_q) != ST_HIGH));

    // R9: the gate is resampled only at a period boundary
    a_r9_gate_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(state_q == ST_HIGH && $past(state_q) != ST_HIGH) |-> $stable(gate_q));

    // R7: remaining count never exceeds the latched phase length
    a_r7_high_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_HIGH) |-> (cnt_q < len_q.hi));

    a_r7_low_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_LOW) |-> (cnt_q < len_q.lo));

endmodule

// File: rtl/clk_compose_cell.sv
module clk_compose_cell
    import ccc_pkg::*;
#(
    parameter int NUM_SEC  = 8,
    parameter bit HAS_MUX  = 1'b1,
    parameter bit HAS_GATE = 1'b1,
    localparam int IDX_W   = $clog2(NUM_SEC + 1)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               prim_tick_i,
    input  logic [NUM_SEC-1:0] sec_tick_i,
    input  logic               src_alt_i,
    input  logic [2:0]         src_sel_i,
    input  logic               div_on_i,
    input  logic [2:0]         div_code_i,
    input  logic               div3_on_i,
    input  logic               en_i,
    output logic               clk_o,
    output logic [IDX_W-1:0]   parent_idx_o
);

    logic             src_tick;
    logic [LEN_W-1:0] ratio;
    phase_len_t       len;
    logic             en_eff;

    ccc_src_select #(
        .NUM_SEC (NUM_SEC),
        .HAS_MUX (HAS_MUX),
        .IDX_W   (IDX_W)
    ) u_src (
        .prim_tick_i (prim_tick_i),
        .sec_tick_i  (sec_tick_i),
        .alt_i       (src_alt_i),
        .sel_i       (src_sel_i),
        .tick_o      (src_tick),
        .idx_o       (parent_idx_o)
    );

    ccc_ratio_decode u_dec (
        .div_on_i (div_on_i),
        .code_i   (div_code_i),
        .div3_i   (div3_on_i),
        .ratio_o  (ratio),
        .len_o    (len)
    );

    generate
        if (HAS_GATE) begin : g_gate
            assign en_eff = en_i;
        end else begin : g_open
            logic unused_en;
            assign unused_en = en_i;
            assign en_eff    = 1'b1;
        end
    endgenerate

    ccc_phase_fsm u_fsm (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_i (src_tick),
        .en_i   (en_eff),
        .len_i  (len),
        .clk_o  (clk_o)
    );

    // R6: divide-by-3 overrides the programmable divider
    a_r6_div3_dominant: assert property (@(posedge clk_i) disable iff (!rst_ni)
        div3_on_i |-> (ratio == LEN_W'(3)));

    // R5: divider bypass gives ratio 1
    a_r5_div_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!div3_on_i && !div_on_i) |-> (ratio == LEN_W'(1)));

    // R2: primary source reports parent index 0
    a_r2_primary_idx: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !src_alt_i |-> (parent_idx_o == '0));

endmodule

// File: tb/clk_compose_cell_bench.sv
`timescale 1ns/1ps
module clk_compose_cell_bench;

    localparam int NSEC = 8;

    typedef struct packed {
        logic       alt;
        logic [2:0] sel;
        logic       don;
        logic [2:0] code;
        logic       d3;
        logic [7:0] per;
        logic [7:0] hi;
        logic [3:0] idx;
    } vec_t;

    // Secondary source i ticks every i+2 cycles; primary every cycle.
    localparam vec_t VECS [15] = '{
        '{1'b0, 3'd0, 1'b1, 3'd0, 1'b0, 8'd2,  8'd1,  4'd0},
        '{1'b0, 3'd0, 1'b1, 3'd1, 1'b0, 8'd4,  8'd2,  4'd0},
        '{1'b0, 3'd0, 1'b1, 3'd2, 1'b0, 8'd8,  8'd4,  4'd0},
        '{1'b0, 3'd0, 1'b1, 3'd3, 1'b0, 8'd12, 8'd6,  4'd0},
        '{1'b0, 3'd0, 1'b1, 3'd4, 1'b0, 8'd16, 8'd8,  4'd0},
        '{1'b0, 3'd0, 1'b1, 3'd5, 1'b0, 8'd24, 8'd12, 4'd0},
        '{1'b0, 3'd0, 1'b1, 3'd6, 1'b0, 8'd2,  8'd1,  4'd0},
        '{1'b0, 3'd0, 1'b1, 3'd7, 1'b0, 8'd2,  8'd1,  4'd0},
        '{1'b0, 3'd0, 1'b0, 3'd5, 1'b0, 8'd2,  8'd1,  4'd0},
        '{1'b0, 3'd0, 1'b1, 3'd5, 1'b1, 8'd6,  8'd2,  4'd0},
        '{1'b0, 3'd0, 1'b0, 3'd4, 1'b1, 8'd6,  8'd2,  4'd0},
        '{1'b1, 3'd0, 1'b1, 3'd1, 1'b0, 8'd8,  8'd4,  4'd1},
        '{1'b1, 3'd3, 1'b1, 3'd2, 1'b1, 8'd30, 8'd10, 4'd4},
        '{1'b1, 3'd7, 1'b1, 3'd0, 1'b0, 8'd18, 8'd9,  4'd8},
        '{1'b1, 3'd2, 1'b1, 3'd2, 1'b0, 8'd32, 8'd16, 4'd3}
    };

    logic            clk;
    logic            rst_n;
    logic            prim_tick;
    logic [NSEC-1:0] sec_tick;
    logic            alt;
    logic [2:0]      sel;
    logic            don;
    logic [2:0]      code;
    logic            d3;
    logic            en;
    logic            clk_main;
    logic            clk_bare;
    logic [3:0]      idx_main;
    logic [3:0]      idx_bare;

    int checks;
    int failures;

    clk_compose_cell #(.NUM_SEC(NSEC)) u_clk_compose_cell (
        .clk_i (clk), .rst_ni (rst_n), .prim_tick_i (prim_tick), .sec_tick_i (sec_tick),
        .src_alt_i (alt), .src_sel_i (sel), .div_on_i (don), .div_code_i (code),
        .div3_on_i (d3), .en_i (en), .clk_o (clk_main), .parent_idx_o (idx_main)
    );

    clk_compose_cell #(.NUM_SEC(NSEC), .HAS_MUX(1'b0), .HAS_GATE(1'b0)) u_clk_compose_cell_bare (
        .clk_i (clk), .rst_ni (rst_n), .prim_tick_i (prim_tick), .sec_tick_i (sec_tick),
        .src_alt_i (alt), .src_sel_i (sel), .div_on_i (don), .div_code_i (code),
        .div3_on_i (d3), .en_i (en), .clk_o (clk_bare), .parent_idx_o (idx_bare)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    // Source tick generator, driven away from the active edge
    initial begin
        int cyc;
        cyc       = 0;
        prim_tick = 1'b1;
        sec_tick  = '0;
        forever begin
            @(negedge clk);
            cyc++;
            for (int i = 0; i < NSEC; i++) begin
                sec_tick[i] = ((cyc % (i + 2)) == 0);
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic cur(input int which);
        return (which == 0) ? clk_main : clk_bare;
    endfunction

    task automatic wait_rise(input int which);
        logic prev;
        prev = cur(which);
        for (int n = 0; n < 1000; n++) begin
            @(negedge clk);
            if (!prev && cur(which)) return;
            prev = cur(which);
        end
    endtask

    // Called just after a rise has been seen; returns high and period length.
    task automatic measure_from_rise(input int which, output int per, output int hi);
        logic prev;
        per  = -1;
        hi   = -1;
        prev = 1'b1;
        for (int n = 1; n < 1000; n++) begin
            @(negedge clk);
            if (hi < 0 && !cur(which)) hi = n;
            if (!prev && cur(which)) begin
                per = n;
                return;
            end
            prev = cur(which);
        end
    endtask

    task automatic measure(input int which, output int per, output int hi);
        wait_rise(which);
        measure_from_rise(which, per, hi);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int per;
        int hi;
        int highs;
        string tag;
        checks   = 0;
        failures = 0;
        rst_n    = 1'b0;
        alt      = 1'b0;
        sel      = 3'd0;
        don      = 1'b1;
        code     = 3'd2;
        d3       = 1'b0;
        en       = 1'b1;

        // R1: output low throughout reset, even with ticks present
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R1", "clk_o in reset", int'(clk_main), 0);
        end
        chk("R1", "bare clk_o in reset", int'(clk_bare), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "first tick starts high", int'(clk_main), 1);
        chk("R2", "parent idx primary", int'(idx_main), 0);

        // Vector walk: ratio table, bypasses, div3, secondary sources
        for (int v = 0; v < 15; v++) begin
            alt  = VECS[v].alt;
            sel  = VECS[v].sel;
            don  = VECS[v].don;
            code = VECS[v].code;
            d3   = VECS[v].d3;
            measure(0, per, hi);
            tag = VECS[v].d3 ? "R6" : (!VECS[v].don ? "R5" : (VECS[v].alt ? "R3" : "R4"));
            chk(tag, $sformatf("vec%0d period", v), per, int'(VECS[v].per));
            chk("R7", $sformatf("vec%0d high", v), hi, int'(VECS[v].hi));
            chk(VECS[v].alt ? "R3" : "R2", $sformatf("vec%0d idx", v),
                int'(idx_main), int'(VECS[v].idx));
        end

        // R8: mid-period setting change keeps the running period
        alt  = 1'b0;
        don  = 1'b1;
        d3   = 1'b0;
        code = 3'd5;
        measure(0, per, hi);
        begin
            logic prev;
            prev = 1'b1;
            per  = -1;
            for (int n = 1; n < 1000; n++) begin
                @(negedge clk);
                if (n == 3) code = 3'd1;
                if (!prev && clk_main) begin
                    per = n;
                    break;
                end
                prev = clk_main;
            end
        end
        chk("R8", "period after mid change", per, 24);
        measure_from_rise(0, per, hi);
        chk("R8", "new period at boundary", per, 4);

        // R9 / R10: enable dropped inside a high phase
        code = 3'd5;
        measure(0, per, hi);
        wait_rise(0);
        hi = -1;
        for (int n = 1; n < 1000; n++) begin
            @(negedge clk);
            if (n == 2) en = 1'b0;
            if (!clk_main) begin
                hi = n;
                break;
            end
        end
        chk("R9", "high not truncated", hi, 12);
        highs = 0;
        for (int n = 0; n < 50; n++) begin
            @(negedge clk);
            if (clk_main) highs++;
        end
        chk("R10", "gated output high cycles", highs, 0);
        en = 1'b1;
        measure(0, per, hi);
        chk("R9", "resume period", per, 24);
        chk("R9", "resume high", hi, 12);

        // R11: stripped variant ignores selector and enable
        alt  = 1'b1;
        sel  = 3'd3;
        code = 3'd2;
        en   = 1'b0;
        measure(1, per, hi);
        chk("R11", "bare period on primary", per, 8);
        chk("R11", "bare high", hi, 4);
        chk("R11", "bare parent idx", int'(idx_bare), 0);
        chk("R3", "main idx sel3", int'(idx_main), 4);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule